// File: doc/BRIEF.md
# Load/Store Alignment Checker

This unit sits between a pipeline's memory stage and a 32-bit data memory that stores bytes most-significant first. Each accepted request carries an access size, a byte address, a load or store flag, store data, a destination register number and a sign-extension flag. The unit decides in the accepting cycle whether the request is legal. On the next clock it either presents a memory beat or raises a one-cycle trap request with a trap code.

A legal byte, half-word or word access becomes one memory beat. The beat carries a word-aligned address, a 4-bit lane mask, and store data moved into the lanes that the address selects. Load data returned by the memory is picked out of its lanes, right-justified and optionally sign-extended. A doubleword access becomes two word beats on consecutive cycles, and the unit refuses new requests while the second beat is pending.

The memory is assumed to return read data combinationally for the address it is shown.

Top module: `lsu_align_check`

## Requirements
- R1: While reset is held low and after its release, `mem_valid`, `trap_valid` and `ld_valid` are 0 and `req_ready` is 1.
- R2: Sizes are encoded 0 byte, 1 half-word, 2 word, 3 doubleword. For a byte access at offset o = addr[1:0], the lane mask has only bit 3-o set, so offset 0 selects bit 3 and the lane `mem_wdata[31:24]`. The store byte is taken from `req_wdata[7:0]`.
- R3: A half-word at offset 0 uses lanes 4'b1100, and at offset 2 it uses 4'b0011. Bits `req_wdata[15:8]` go to the lower address.
- R4: A word at offset 0 uses mask 4'b1111 and passes `req_wdata[31:0]` unchanged. `mem_addr` always has its two low bits cleared, and `mem_addr[31:2]` equals the request address bits [31:2].
- R5: An access not aligned to its own size is a misalignment. It sets `trap_valid` with `trap_type` 7 on the next cycle, and no memory beat is issued for it.
- R6: A doubleword with an odd `req_rd` and an aligned address traps with `trap_type` 2 and issues no beat. When a doubleword is both misaligned and odd, code 7 wins.
- R7: A legal doubleword issues beat 0 at the request address, then beat 1 at that address plus 4 on the following cycle. Beat 0 stores `req_wdata[63:32]` and loads register `req_rd`. Beat 1 stores `req_wdata[31:0]` and loads `req_rd`+1. `mem_beat` gives the beat index, and a request offered during the cycle in which `req_ready` is 0 has no effect.
- R8: A load produces `ld_valid` with its beat. The byte or half-word is right-justified in `ld_data` and is sign-extended when `req_sext` was 1, otherwise zero-extended. A word is returned unchanged.
- R9: A trap lasts exactly one cycle for each offending request, and `trap_valid` is low in the cycle after it unless another offending request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (low while a second doubleword beat is pending) |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| req_sext | input | 1 | Sign-extend loaded byte or half |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Store data, right-justified; doubleword uses all 64 bits |
| req_rd | input | 5 | Destination or source register number |
| mem_valid | output | 1 | Memory beat this cycle |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_be | output | 4 | Lane mask, bit 3 is the lowest-addressed byte |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_beat | output | 1 | Beat index within a doubleword |
| mem_rdata | input | 32 | Read data for `mem_addr` |
| ld_valid | output | 1 | Load result valid |
| ld_rd | output | 5 | Register receiving `ld_data` |
| ld_data | output | 32 | Extracted load data |
| trap_valid | output | 1 | Trap request, one cycle |
| trap_type | output | 8 | Trap code (7 misaligned, 2 bad register pair) |

## Verification
Stores are sent at every offset that is legal for each size. This separates a lane mapping that runs from the wrong end from a correct one. Loads of the same bytes are made with and without sign extension on data whose top bit is set, which exposes a missing or misplaced extension. Each illegal case is sent on its own, and the doubleword that is both misaligned and odd shows which check has priority. Doublewords at the top of the address space, and with a request held during the second beat, show whether the address increments correctly and whether a busy cycle wrongly accepts a request.

// File: rtl/lsac_pkg.sv
// Package: shared access-size encoding and trap codes for the alignment checker.
// Assumes: size encoding is fixed by the requester (0 byte .. 3 doubleword).
package lsac_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam int unsigned TT_W       = 8;
    localparam logic [7:0]  TT_MISALIGN = 8'h07;
    localparam logic [7:0]  TT_BAD_PAIR = 8'h02;
endpackage

// File: rtl/lsac_decode.sv
// Module: lsac_decode
// Classifies one request: natural-alignment fault, odd register pair fault,
// and the lane mask. Lane bit 3 is the lowest-addressed (most significant) byte.
// Assumes: purely combinational; priority between faults is resolved by the caller.
module lsac_decode
    import lsac_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  acc_size_e        size,
    input  logic [2:0]       addr_lo,
    input  logic [REG_W-1:0] rd,
    output logic             misalign,
    output logic             bad_pair,
    output logic [3:0]       be
);
    // Alignment test for each access size
    always_comb begin
        unique case (size)
            SZ_BYTE:  misalign = 1'b0;
            SZ_HALF:  misalign = addr_lo[0];
            SZ_WORD:  misalign = |addr_lo[1:0];
            default:  misalign = |addr_lo[2:0];
        endcase
    end

    // A doubleword must name the even register of a pair
    assign bad_pair = (size == SZ_DWORD) && rd[0];

    // Lane mask: the access starts at lane (3 - offset) and runs downward
    always_comb begin
        unique case (size)
            SZ_BYTE:  be = 4'b1000 >> addr_lo[1:0];
            SZ_HALF:  be = 4'b1100 >> addr_lo[1:0];
            default:  be = 4'b1111;
        endcase
    end
endmodule

// File: rtl/lsac_store_steer.sv
// Module: lsac_store_steer
// Moves right-justified store data into the big-endian lanes chosen by the offset.
// Assumes: offset already checked for alignment; word and doubleword pass through.
module lsac_store_steer
    import lsac_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_size_e         size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lanes
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;

    // Shift amount puts the access's last byte at lane (3 - offset - n + 1)
    always_comb begin
        unique case (size)
            SZ_BYTE: shamt = SH_W'((3 - off) * 8);
            SZ_HALF: shamt = SH_W'((2 - off) * 8);
            default: shamt = '0;
        endcase
    end

    // Select and place the significant bytes
    always_comb begin
        unique case (size)
            SZ_BYTE: lanes = {{(DATA_W-8){1'b0}},  wdata[7:0]}  << shamt;
            SZ_HALF: lanes = {{(DATA_W-16){1'b0}}, wdata[15:0]} << shamt;
            default: lanes = wdata;
        endcase
    end
endmodule

// File: rtl/lsac_load_steer.sv
// Module: lsac_load_steer
// Pulls a byte or half-word out of a big-endian read word, right-justifies it
// and extends it. Word and doubleword beats are returned unchanged.
// Assumes: offset is aligned for the size.
module lsac_load_steer
    import lsac_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_size_e         size,
    input  logic [1:0]        off,
    input  logic              sext,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] shifted;

    // Bring the addressed bytes down to bit 0
    always_comb begin
        unique case (size)
            SZ_BYTE: shifted = rdata >> SH_W'((3 - off) * 8);
            SZ_HALF: shifted = rdata >> SH_W'((2 - off) * 8);
            default: shifted = rdata;
        endcase
    end

    // Extend the narrow value with zeros or its top bit
    always_comb begin
        unique case (size)
            SZ_BYTE: data = {{(DATA_W-8){sext & shifted[7]}},   shifted[7:0]};
            SZ_HALF: data = {{(DATA_W-16){sext & shifted[15]}}, shifted[15:0]};
            default: data = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_align_check.sv
// Module: lsu_align_check (top)
// Accepts one load/store request per cycle, checks natural alignment and the
// even-register rule for doublewords, and on the next clock issues a memory
// beat or a one-cycle trap. A doubleword is split into two word beats; the
// even register takes the lower address.
// Assumes: memory returns mem_rdata combinationally for mem_addr.
module lsu_align_check
    import lsac_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic                req_sext,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*DATA_W-1:0] req_wdata,
    input  logic [REG_W-1:0]    req_rd,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [3:0]          mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_beat,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                ld_valid,
    output logic [REG_W-1:0]    ld_rd,
    output logic [DATA_W-1:0]   ld_data,
    output logic                trap_valid,
    output logic [TT_W-1:0]     trap_type
);
    localparam int unsigned BYTES_W = DATA_W / 8;

    acc_size_e         size_in;
    logic              misalign, bad_pair, accept;
    logic [3:0]        be_in;
    logic [DATA_W-1:0] st_lanes;

    // Held state of the issued beat
    acc_size_e         r_size;
    logic [1:0]        r_off;
    logic              r_sext;
    logic              pend;
    logic [DATA_W-1:0] pend_wdata;

    assign size_in   = acc_size_e'(req_size);
    assign req_ready = !pend;
    assign accept    = req_valid && req_ready;

    lsac_decode #(.REG_W(REG_W)) u_decode (
        .size     (size_in),
        .addr_lo  (req_addr[2:0]),
        .rd       (req_rd),
        .misalign (misalign),
        .bad_pair (bad_pair),
        .be       (be_in)
    );

    lsac_store_steer #(.DATA_W(DATA_W)) u_st (
        .size  (size_in),
        .off   (req_addr[1:0]),
        .wdata (req_wdata[DATA_W-1:0]),
        .lanes (st_lanes)
    );

    lsac_load_steer #(.DATA_W(DATA_W)) u_ld (
        .size  (r_size),
        .off   (r_off),
        .sext  (r_sext),
        .rdata (mem_rdata),
        .data  (ld_data)
    );

    assign ld_valid = mem_valid && !mem_we;

    // Request acceptance, trap generation and doubleword beat sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid  <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_be     <= '0;
            mem_wdata  <= '0;
            mem_beat   <= 1'b0;
            ld_rd      <= '0;
            r_size     <= SZ_BYTE;
            r_off      <= '0;
            r_sext     <= 1'b0;
            pend       <= 1'b0;
            pend_wdata <= '0;
            trap_valid <= 1'b0;
            trap_type  <= '0;
        end else begin
            mem_valid  <= 1'b0;
            trap_valid <= 1'b0;
            if (accept) begin
                if (misalign) begin
                    trap_valid <= 1'b1;
                    trap_type  <= TT_MISALIGN;
                end else if (bad_pair) begin
                    trap_valid <= 1'b1;
                    trap_type  <= TT_BAD_PAIR;
                end else begin
                    mem_valid <= 1'b1;
                    mem_we    <= req_store;
                    mem_addr  <= {req_addr[ADDR_W-1:2], 2'b00};
                    mem_be    <= be_in;
                    mem_beat  <= 1'b0;
                    ld_rd     <= req_rd;
                    r_size    <= size_in;
                    r_off     <= req_addr[1:0];
                    r_sext    <= req_sext;
                    if (size_in == SZ_DWORD) begin
                        mem_wdata  <= req_wdata[2*DATA_W-1:DATA_W];
                        pend_wdata <= req_wdata[DATA_W-1:0];
                        pend       <= 1'b1;
                    end else begin
                        mem_wdata <= st_lanes;
                    end
                end
            end else if (pend) begin
                mem_valid <= 1'b1;
                mem_addr  <= mem_addr + ADDR_W'(BYTES_W);
                mem_be    <= '1;
                mem_wdata <= pend_wdata;
                mem_beat  <= 1'b1;
                ld_rd     <= ld_rd | REG_W'(1);
                pend      <= 1'b0;
            end
        end
    end

    // R5: a trap cycle never carries a memory beat
    assert_trap_no_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_valid && mem_valid));

    // R9: every trap cycle comes from a request accepted on the previous clock
    assert_trap_from_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> $past(req_valid && req_ready));

    // R6: the register-pair trap only follows a doubleword request
    assert_pair_trap_dword_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_type == TT_BAD_PAIR) |-> $past(req_size) == 2'd3);

    // R4: a beat always has a word-aligned address and a non-empty mask
    assert_beat_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00 && mem_be != 4'b0000));

    // R7: a first beat with the unit busy is followed by the second beat four bytes on
    assert_second_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_beat && !req_ready) |=>
            (mem_valid && mem_beat && mem_addr == $past(mem_addr) + ADDR_W'(4)));

    // R1: idle while the unit is not busy means ready
    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid) |-> req_ready);
endmodule

// File: tb/lsu_align_check_tb.sv
module lsu_align_check_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_sext;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic [63:0] req_wdata;
    logic [4:0]  req_rd;
    logic        req_ready;
    logic        mem_valid, mem_we, mem_beat, ld_valid, trap_valid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
    logic [3:0]  mem_be;
    logic [4:0]  ld_rd;
    logic [7:0]  trap_type;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Bench memory: read word is a fixed function of the address
    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h9A5B_8C3D;
    endfunction
    assign mem_rdata = memf(mem_addr);

    lsu_align_check u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_size(req_size), .req_sext(req_sext),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_rd(req_rd),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_beat(mem_beat), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_rd(ld_rd), .ld_data(ld_data),
        .trap_valid(trap_valid), .trap_type(trap_type)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: number of bytes for a size code
    function automatic int nb(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    // Reference lane mask: byte at address offset i lives in mask bit 3-i
    function automatic logic [3:0] ref_be(input logic [1:0] s, input int off);
        logic [3:0] m = '0;
        for (int i = 0; i < 4; i++)
            if (i >= off && i < off + nb(s)) m[3-i] = 1'b1;
        return m;
    endfunction

    // Reference store lanes: first address receives the most significant byte
    function automatic logic [31:0] ref_wd(input logic [1:0] s, input int off, input logic [63:0] w);
        logic [31:0] r = '0;
        int n = nb(s);
        if (s >= 2'd2) return w[31:0];
        for (int i = 0; i < 4; i++)
            if (i >= off && i < off + n) r[8*(3-i) +: 8] = w[8*(n-1-(i-off)) +: 8];
        return r;
    endfunction

    // Reference load: gather bytes in address order, then extend
    function automatic logic [31:0] ref_ld(input logic [1:0] s, input int off, input logic sx,
                                          input logic [31:0] rw);
        longint v = 0;
        int n = nb(s);
        for (int j = 0; j < n; j++) v = (v << 8) | longint'(rw[8*(3-(off+j)) +: 8]);
        if (sx && n < 4 && v[8*n-1]) v = v - (longint'(1) << (8*n));
        return v[31:0];
    endfunction

    // One request, with per-cycle comparison of every output against the model
    task automatic run(input string tag, input logic st, input logic [1:0] s, input logic [31:0] a,
                       input logic [4:0] rd, input logic sx, input logic [63:0] w);
        int  off   = int'(a[1:0]);
        bit  mis   = (s == 2'd1 && a[0]) || (s == 2'd2 && a[1:0] != 0) || (s == 2'd3 && a[2:0] != 0);
        bit  pair  = (s == 2'd3) && rd[0];
        logic [31:0] wa = {a[31:2], 2'b00};
        @(negedge clk);
        check({tag, " R1 ready before request"}, req_ready, 1'b1);
        req_valid = 1'b1; req_store = st; req_size = s; req_addr = a; req_rd = rd;
        req_sext = sx; req_wdata = w;
        @(negedge clk);
        if (s == 2'd3 && !mis && !pair) begin
            // keep offering a misaligned request while the unit is busy (R7)
            req_store = 1'b0; req_size = 2'd2; req_addr = 32'h0000_0003;
        end else begin
            req_valid = 1'b0;
        end
        if (mis || pair) begin
            check({tag, " R5/R6 trap_valid"}, trap_valid, 1'b1);
            check({tag, " R5/R6 trap_type"}, trap_type, mis ? 8'h07 : 8'h02);
            check({tag, " R5 no beat on trap"}, mem_valid, 1'b0);
        end else begin
            check({tag, " R4 beat valid"}, mem_valid, 1'b1);
            check({tag, " R4 addr"}, mem_addr, wa);
            check({tag, " R2/R3 mask"}, mem_be, (s == 2'd3) ? 4'hF : ref_be(s, off));
            check({tag, " R7 beat index"}, mem_beat, 1'b0);
            check({tag, " R9 no trap"}, trap_valid, 1'b0);
            if (st) check({tag, " R2/R3/R7 wdata"}, mem_wdata, (s == 2'd3) ? w[63:32] : ref_wd(s, off, w));
            else begin
                check({tag, " R8 ld_valid"}, ld_valid, 1'b1);
                check({tag, " R8 ld_data"}, ld_data,
                      (s == 2'd3) ? memf(wa) : ref_ld(s, off, sx, memf(wa)));
                check({tag, " R7 ld_rd"}, ld_rd, rd);
            end
            if (s == 2'd3) begin
                check({tag, " R7 busy"}, req_ready, 1'b0);
                @(negedge clk);
                req_valid = 1'b0;
                check({tag, " R7 beat1 valid"}, mem_valid, 1'b1);
                check({tag, " R7 beat1 index"}, mem_beat, 1'b1);
                check({tag, " R7 beat1 addr"}, mem_addr, wa + 32'd4);
                if (st) check({tag, " R7 beat1 wdata"}, mem_wdata, w[31:0]);
                else begin
                    check({tag, " R7 beat1 ld_data"}, ld_data, memf(wa + 32'd4));
                    check({tag, " R7 beat1 ld_rd"}, ld_rd, rd + 5'd1);
                end
            end
        end
        @(negedge clk);
        check({tag, " R9/R7 idle after"}, {trap_valid, mem_valid}, 2'b00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0; req_sext = 1'b0;
        req_addr = '0; req_wdata = '0; req_rd = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {mem_valid, trap_valid, ld_valid, req_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {mem_valid, trap_valid, ld_valid, req_ready}, 4'b0001);

        for (int o = 0; o < 4; o++)
            run("R2 byte store", 1'b1, 2'd0, 32'h0000_1000 + o, 5'd3, 1'b0, 64'h1122_3344_5566_77A9);
        run("R3 half store off0", 1'b1, 2'd1, 32'h0000_2000, 5'd4, 1'b0, 64'h0000_0000_0000_BEEF);
        run("R3 half store off2", 1'b1, 2'd1, 32'h0000_2002, 5'd4, 1'b0, 64'h0000_0000_0000_BEEF);
        run("R4 word store", 1'b1, 2'd2, 32'h8000_0004, 5'd5, 1'b0, 64'h0000_0000_CAFE_F00D);
        for (int o = 0; o < 4; o++) begin
            run("R8 byte load signed", 1'b0, 2'd0, 32'h0000_3100 + o, 5'd6, 1'b1, 64'd0);
            run("R8 byte load unsigned", 1'b0, 2'd0, 32'h0000_3100 + o, 5'd6, 1'b0, 64'd0);
        end
        run("R8 half load signed off2", 1'b0, 2'd1, 32'h0000_7FF2, 5'd7, 1'b1, 64'd0);
        run("R8 half load unsigned off0", 1'b0, 2'd1, 32'h0000_7FF0, 5'd7, 1'b0, 64'd0);
        run("R8 word load", 1'b0, 2'd2, 32'h0000_4444, 5'd8, 1'b1, 64'd0);
        run("R5 half off1", 1'b1, 2'd1, 32'h0000_2001, 5'd4, 1'b0, 64'd0);
        run("R5 word off2", 1'b0, 2'd2, 32'h0000_2002, 5'd4, 1'b0, 64'd0);
        run("R5 word off3", 1'b1, 2'd2, 32'h0000_2003, 5'd4, 1'b0, 64'd0);
        run("R5 dword off4", 1'b0, 2'd3, 32'h0000_2004, 5'd4, 1'b0, 64'd0);
        run("R6 dword odd rd", 1'b1, 2'd3, 32'h0000_2008, 5'd5, 1'b0, 64'd0);
        run("R6 dword odd and misaligned", 1'b1, 2'd3, 32'h0000_200C, 5'd9, 1'b0, 64'd0);
        run("R7 dword store", 1'b1, 2'd3, 32'h0000_5008, 5'd10, 1'b0, 64'hAAAA_0001_BBBB_0002);
        run("R7 dword load top", 1'b0, 2'd3, 32'hFFFF_FFF8, 5'd12, 1'b0, 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule